// File: doc/BRIEF.md
# Direct-Mapped Cache with Selectable Write Policy

This block places 1K words of direct-mapped storage between a processor and a word-addressed main memory of 64K sixteen-bit words. The processor issues one read or write at a time over a request/ready pair. Each access either hits and completes in its first cycle, or misses and stalls while the line is refilled over a single-word memory port. Misses allocate the line for both reads and writes.

A build parameter selects the write policy. With write-through, every processor write is also sent to memory. With write-back, writes stay in the cache and mark the line as modified. A modified line is copied out as a four-word burst when a conflicting address replaces it. Geometry is parameterised, and the defaults give 256 lines of four words.

Top module: `dmc_cache`

## Requirements
- R1: The 16-bit word address splits into tag = bits [15:10], line index = bits [9:2] and word offset = bits [1:0]. Two addresses with equal tag and index share one line, so after a miss on one of them the other hits.
- R2: Reset empties every line and clears every modified mark. With no request pending, ready is high. The first access to any address after reset misses, and data written before the reset but never written back is not copied to memory.
- R3: A hit completes with cpu_ready_o high in the cycle the request is presented. A read hit returns the word on cpu_rdata_o in that cycle. A write hit under write-back also completes in that cycle.
- R4: A miss reads the whole block from memory as exactly four single-word reads at offsets 0, 1, 2, 3 in that order, beginning at offset 0. cpu_ready_o stays low while any memory request is outstanding. The access then completes as a hit.
- R5: Under write-through, every processor write issues exactly one memory write carrying the processor's address and data, and updates the cached word. The write completes in the cycle the memory acknowledges.
- R6: Under write-back, a processor write that hits produces no memory traffic and marks the line modified.
- R7: Under write-back, replacing a modified line first writes its four words to the old line's address, at offsets 0 to 3, and then refills. Replacing an unmodified line writes nothing.
- R8: The memory port holds mem_req_o, mem_we_o, mem_addr_o and mem_wdata_o stable until mem_ack_i. Each acknowledge ends one word transfer, and read data is taken in the acknowledge cycle.
- R9: A read returns the most recent value written to that address. Main memory is the source when the address has not been written since the last reset, and under write-back a reset discards unwritten modified data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Access request, held until ready |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 16 | Word address |
| cpu_wdata_i | input | 16 | Write data |
| cpu_rdata_o | output | 16 | Read data, valid when ready on a read |
| cpu_ready_o | output | 1 | Access completes at this clock edge |
| mem_req_o | output | 1 | Memory word transfer request |
| mem_we_o | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid with acknowledge |
| mem_ack_i | input | 1 | One-cycle acknowledge of a word transfer |

## Verification
The bench builds two instances with the default geometry side by side: u0 with WRITE_BACK=1 and u1 with WRITE_BACK=0. Both receive the same processor stream. Each instance has its own memory model, so the write-back counts, the write-through counts and the memory contents can be compared with the bench's own model of each policy. Random addresses keep the tag to four values and mostly to a few lines. This forces frequent conflicts, so clean evictions, modified evictions and hits all occur. A mid-run reset with modified lines outstanding shows that modified data not yet written back is lost.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_WTW
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             fill_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             dirty_set_i,
  output logic             valid_o,
  output logic             dirty_o,
  output logic [TAG_W-1:0] tag_o
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= 1'b0;
    end else if (dirty_set_i) begin
      dirty_q[idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) tag_q[idx_i] <= tag_i;
  end

  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_q[idx_i];
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int AW     = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int WORDS = 1 << AW;

  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int IDX_W      = 8,
  parameter int OFF_W      = 2,
  parameter bit WRITE_BACK = 1'b1,
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W,
  localparam int LW        = IDX_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  req_tag_o,
  input  logic              line_valid_i,
  input  logic              line_dirty_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  output logic              fill_o,
  output logic              dirty_set_o,
  output logic              data_we_o,
  output logic [LW-1:0]     data_waddr_o,
  output logic [DATA_W-1:0] data_wdata_o,
  output logic [LW-1:0]     data_raddr_o,
  input  logic [DATA_W-1:0] data_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i
);
  localparam logic [OFF_W-1:0] LAST_BEAT = '1;

  dmc_state_e       state_q, state_d;
  logic [OFF_W-1:0] beat_q, beat_d;
  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] idx;
  logic [OFF_W-1:0] off;
  logic             hit;

  assign req_tag   = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign idx       = cpu_addr_i[OFF_W +: IDX_W];
  assign off       = cpu_addr_i[OFF_W-1:0];
  assign hit       = line_valid_i && (line_tag_i == req_tag);
  assign idx_o     = idx;
  assign req_tag_o = req_tag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  always_comb begin
    state_d      = state_q;
    beat_d       = beat_q;
    cpu_ready_o  = 1'b0;
    fill_o       = 1'b0;
    dirty_set_o  = 1'b0;
    data_we_o    = 1'b0;
    data_waddr_o = {idx, off};
    data_wdata_o = cpu_wdata_i;
    data_raddr_o = {idx, off};
    mem_req_o    = 1'b0;
    mem_we_o     = 1'b0;
    mem_addr_o   = cpu_addr_i;
    mem_wdata_o  = cpu_wdata_i;
    unique case (state_q)
      ST_IDLE: begin
        if (!cpu_req_i) begin
          cpu_ready_o = 1'b1;
        end else if (hit) begin
          if (cpu_we_i && !WRITE_BACK) begin
            state_d = ST_WTW;
          end else begin
            cpu_ready_o = 1'b1;
            if (cpu_we_i) begin
              data_we_o   = 1'b1;
              dirty_set_o = 1'b1;
            end
          end
        end else begin
          beat_d  = '0;
          state_d = (WRITE_BACK && line_valid_i && line_dirty_i) ? ST_EVICT : ST_FILL;
        end
      end
      ST_EVICT: begin
        mem_req_o    = 1'b1;
        mem_we_o     = 1'b1;
        mem_addr_o   = {line_tag_i, idx, beat_q};
        data_raddr_o = {idx, beat_q};
        mem_wdata_o  = data_rdata_i;
        if (mem_ack_i) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == LAST_BEAT) state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {req_tag, idx, beat_q};
        if (mem_ack_i) begin
          data_we_o    = 1'b1;
          data_waddr_o = {idx, beat_q};
          data_wdata_o = mem_rdata_i;
          beat_d       = beat_q + 1'b1;
          if (beat_q == LAST_BEAT) begin
            fill_o  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_WTW: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        if (mem_ack_i) begin
          data_we_o   = 1'b1;
          cpu_ready_o = 1'b1;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int IDX_W      = 8,
  parameter int OFF_W      = 2,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int LW    = IDX_W + OFF_W;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  req_tag, line_tag;
  logic              line_valid, line_dirty, fill, dirty_set;
  logic              data_we;
  logic [LW-1:0]     data_waddr, data_raddr;
  logic [DATA_W-1:0] data_wdata, data_rdata;

  dmc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
    .WRITE_BACK(WRITE_BACK)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i),
    .cpu_wdata_i(cpu_wdata_i), .cpu_ready_o(cpu_ready_o),
    .idx_o(idx), .req_tag_o(req_tag),
    .line_valid_i(line_valid), .line_dirty_i(line_dirty), .line_tag_i(line_tag),
    .fill_o(fill), .dirty_set_o(dirty_set),
    .data_we_o(data_we), .data_waddr_o(data_waddr), .data_wdata_o(data_wdata),
    .data_raddr_o(data_raddr), .data_rdata_i(data_rdata),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i)
  );

  dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk_i(clk_i), .rst_ni(rst_ni), .idx_i(idx), .fill_i(fill),
    .tag_i(req_tag), .dirty_set_i(dirty_set),
    .valid_o(line_valid), .dirty_o(line_dirty), .tag_o(line_tag)
  );

  dmc_data_store #(.AW(LW), .DATA_W(DATA_W)) u_data (
    .clk_i(clk_i), .we_i(data_we), .waddr_i(data_waddr), .wdata_i(data_wdata),
    .raddr_i(data_raddr), .rdata_o(data_rdata)
  );

  assign cpu_rdata_o = data_rdata;
endmodule

// File: rtl/dmc_cache_chk.sv
module dmc_cache_chk #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int OFF_W      = 2,
  parameter bit WRITE_BACK = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_we_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic [DATA_W-1:0] cpu_wdata_i,
  input logic              cpu_ready_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ack_i
);
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                   && $stable(mem_wdata_o))); // R8

  AST_MISS_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |-> !cpu_ready_o); // R4

  AST_FILL_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_req_o) && !mem_we_o) |-> (mem_addr_o[OFF_W-1:0] == '0)); // R4

  AST_FILL_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && !mem_we_o && (mem_addr_o[OFF_W-1:0] != '1))
    |=> (mem_req_o && !mem_we_o &&
         mem_addr_o[OFF_W-1:0] == OFF_W'($past(mem_addr_o[OFF_W-1:0]) + 1'b1))); // R4

  AST_WT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!WRITE_BACK && mem_req_o && mem_we_o)
    |-> (mem_addr_o == cpu_addr_i && mem_wdata_o == cpu_wdata_i)); // R5

  AST_WB_HIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (WRITE_BACK && cpu_req_i && cpu_we_i && cpu_ready_o) |-> !mem_req_o); // R6
endmodule

bind dmc_cache dmc_cache_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .WRITE_BACK(WRITE_BACK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i),
  .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i), .cpu_ready_o(cpu_ready_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i)
);

// File: tb/sim_dmc_cache.sv
module sim_dmc_cache;
  localparam int CLK_P = 10;
  localparam int MW    = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req0 = 1'b0, req1 = 1'b0, we = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic [15:0] rdata0, rdata1;
  logic        ready0, ready1;
  logic        mreq0, mwe0, mreq1, mwe1;
  logic [15:0] maddr0, mwd0, maddr1, mwd1;
  logic [15:0] mrd0 = '0, mrd1 = '0;
  logic        mack0 = 1'b0, mack1 = 1'b0;
  logic        init_done = 1'b0;

  logic [15:0] mem0 [MW];
  logic [15:0] mem1 [MW];
  int rd_cnt0 = 0, wr_cnt0 = 0, rd_cnt1 = 0, wr_cnt1 = 0;

  logic [15:0] ref0 [MW];
  logic [15:0] ref1 [MW];
  logic [15:0] exp_mem0 [MW];
  logic [5:0]  t0 [256];
  logic [5:0]  t1 [256];
  logic        v0 [256];
  logic        d0 [256];
  logic        v1 [256];

  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] init_val(input int a);
    int x;
    x = a * 40503 + 7;
    return x[15:0] ^ 16'h3c5a;
  endfunction

  dmc_cache #(.WRITE_BACK(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(req0), .cpu_we_i(we), .cpu_addr_i(addr),
    .cpu_wdata_i(wdata), .cpu_rdata_o(rdata0), .cpu_ready_o(ready0),
    .mem_req_o(mreq0), .mem_we_o(mwe0), .mem_addr_o(maddr0), .mem_wdata_o(mwd0),
    .mem_rdata_i(mrd0), .mem_ack_i(mack0)
  );

  dmc_cache #(.WRITE_BACK(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(req1), .cpu_we_i(we), .cpu_addr_i(addr),
    .cpu_wdata_i(wdata), .cpu_rdata_o(rdata1), .cpu_ready_o(ready1),
    .mem_req_o(mreq1), .mem_we_o(mwe1), .mem_addr_o(maddr1), .mem_wdata_o(mwd1),
    .mem_rdata_i(mrd1), .mem_ack_i(mack1)
  );

  always @(posedge clk) begin
    if (!init_done) begin
      for (int i = 0; i < MW; i++) begin
        mem0[i] <= init_val(i);
        mem1[i] <= init_val(i);
      end
      init_done <= 1'b1;
      mack0 <= 1'b0;
      mack1 <= 1'b0;
    end else if (!rst_n) begin
      mack0 <= 1'b0;
      mack1 <= 1'b0;
    end else begin
      if (mack0) mack0 <= 1'b0;
      else if (mreq0) begin
        mack0 <= 1'b1;
        mrd0  <= mem0[maddr0[11:0]];
        if (mwe0) begin mem0[maddr0[11:0]] <= mwd0; wr_cnt0 <= wr_cnt0 + 1; end
        else rd_cnt0 <= rd_cnt0 + 1;
      end
      if (mack1) mack1 <= 1'b0;
      else if (mreq1) begin
        mack1 <= 1'b1;
        mrd1  <= mem1[maddr1[11:0]];
        if (mwe1) begin mem1[maddr1[11:0]] <= mwd1; wr_cnt1 <= wr_cnt1 + 1; end
        else rd_cnt1 <= rd_cnt1 + 1;
      end
    end
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) begin
      v0[i] = 1'b0; d0[i] = 1'b0; v1[i] = 1'b0;
    end
    for (int i = 0; i < MW; i++) ref0[i] = exp_mem0[i];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req0 = 1'b0; req1 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  task automatic access(input bit w, input logic [15:0] a, input logic [15:0] d);
    logic [7:0]  idx;
    logic [5:0]  tg, ot;
    bit          m0, e0, m1, f0, f1;
    int          ai, cyc, l0, l1, s_rd0, s_wr0, s_rd1, s_wr1;
    logic [15:0] r0, r1;
    idx = a[9:2];
    tg  = a[15:10];
    ai  = int'(a[11:0]);
    m0  = !(v0[idx] && t0[idx] == tg);
    e0  = m0 && v0[idx] && d0[idx];
    ot  = t0[idx];
    m1  = !(v1[idx] && t1[idx] == tg);
    s_rd0 = rd_cnt0; s_wr0 = wr_cnt0; s_rd1 = rd_cnt1; s_wr1 = wr_cnt1;
    r0 = '0; r1 = '0; l0 = 0; l1 = 0; f0 = 0; f1 = 0; cyc = 0;
    @(negedge clk);
    req0 = 1'b1; req1 = 1'b1; we = w; addr = a; wdata = d;
    while (!(f0 && f1) && cyc < 200) begin
      #1;
      cyc++;
      if (!f0 && ready0) begin f0 = 1; r0 = rdata0; l0 = cyc; end
      if (!f1 && ready1) begin f1 = 1; r1 = rdata1; l1 = cyc; end
      @(negedge clk);
      if (f0) req0 = 1'b0;
      if (f1) req1 = 1'b0;
    end
    req0 = 1'b0; req1 = 1'b0;
    chk("R4 access completes", f0 && f1, cyc, 200);
    if (!w) begin
      chk("R9 wb read data", r0 == ref0[ai], int'(r0), int'(ref0[ai]));
      chk("R9 wt read data", r1 == ref1[ai], int'(r1), int'(ref1[ai]));
    end
    // hit latency / miss stall
    if (m0) chk("R4 wb miss stalls", l0 >= 9, l0, 9);
    else    chk("R3 wb hit one cycle", l0 == 1, l0, 1);
    if (m1)      chk("R4 wt miss stalls", l1 >= 9, l1, 9);
    else if (!w) chk("R3 wt read hit one cycle", l1 == 1, l1, 1);
    chk("R4 wb block reads", rd_cnt0 - s_rd0 == (m0 ? 4 : 0), rd_cnt0 - s_rd0, m0 ? 4 : 0);
    chk("R4 wt block reads", rd_cnt1 - s_rd1 == (m1 ? 4 : 0), rd_cnt1 - s_rd1, m1 ? 4 : 0);
    chk("R7 wb write-back count", wr_cnt0 - s_wr0 == (e0 ? 4 : 0), wr_cnt0 - s_wr0, e0 ? 4 : 0);
    chk("R5 wt write count", wr_cnt1 - s_wr1 == (w ? 1 : 0), wr_cnt1 - s_wr1, w ? 1 : 0);
    if (e0) begin
      for (int j = 0; j < 4; j++) begin
        int oa;
        oa = int'({ot[1:0], idx, 2'(j)});
        exp_mem0[oa] = ref0[oa];
        chk("R7 evicted word in memory", mem0[oa] == exp_mem0[oa], int'(mem0[oa]), int'(exp_mem0[oa]));
      end
    end
    if (w) begin
      chk("R5 wt memory updated", mem1[ai] == d, int'(mem1[ai]), int'(d));
      chk("R6 wb memory untouched", mem0[ai] == exp_mem0[ai], int'(mem0[ai]), int'(exp_mem0[ai]));
    end
    if (m0) begin t0[idx] = tg; v0[idx] = 1'b1; d0[idx] = 1'b0; end
    if (w) d0[idx] = 1'b1;
    if (m1) begin t1[idx] = tg; v1[idx] = 1'b1; end
    if (w) begin ref0[ai] = d; ref1[ai] = d; end
  endtask

  initial begin
    #(CLK_P * 190000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1d2c;
    void'($urandom(seed));
    for (int i = 0; i < MW; i++) begin
      ref0[i] = init_val(i); ref1[i] = init_val(i); exp_mem0[i] = init_val(i);
    end
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R2 ready idle after reset wb", ready0 == 1'b1, int'(ready0), 1);
    chk("R2 ready idle after reset wt", ready1 == 1'b1, int'(ready1), 1);

    // R2: first access misses
    access(1'b0, 16'h0000, 16'h0);
    // R1: same line, other offsets hit
    access(1'b0, 16'h0003, 16'h0);
    access(1'b1, 16'h0001, 16'hbeef);
    access(1'b0, 16'h0001, 16'h0);
    // R7: conflicting tag evicts modified line
    access(1'b0, 16'h0400, 16'h0);
    // clean line replaced, no write-back
    access(1'b0, 16'h0800, 16'h0);
    // top line, last offset
    access(1'b1, 16'h03ff, 16'h1234);
    access(1'b0, 16'h0bff, 16'h0);
    access(1'b0, 16'h03ff, 16'h0);

    for (int n = 0; n < 700; n++) begin
      logic [15:0] a;
      logic [7:0]  ix;
      ix = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 6);
      a  = {4'h0, 2'($urandom), ix, 2'($urandom)};
      access(1'($urandom % 2), a, 16'($urandom));
    end

    // R2: reset with modified lines drops them, no write-back
    access(1'b1, 16'h0010, 16'hcafe);
    do_reset();
    access(1'b0, 16'h0010, 16'h0);
    access(1'b0, 16'h0410, 16'h0);

    for (int n = 0; n < 200; n++) begin
      logic [15:0] a;
      a = {4'h0, 2'($urandom), 8'($urandom % 4), 2'($urandom)};
      access(1'($urandom % 2), a, 16'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule